// File: doc/BRIEF.md
# Program Counter and Branch Target Unit

This block owns the 16-bit program counter of a small 8-bit controller core and works out, in one combinational pass, where the next instruction starts. The decoder supplies a class code, the instruction length and up to three instruction bytes. The datapath supplies the accumulator, the 16-bit data pointer and, on a return, the two bytes just read off the stack. The unit covers straight-line flow, short signed displacements, jumps and calls confined to a 2 KB page, full 16-bit jumps and calls, computed jumps, and returns.

Next to the PC it forms the code-memory address for table lookups, where the accumulator is added either to the data pointer or to the PC after that PC has stepped past the lookup instruction. For a call it presents the return address as two stack bytes. The core's stack logic writes the low byte first and the high byte second. The PC loads `next_pc` on every clock edge where `step` is high.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset the PC holds 0x0000.
- R2: The PC changes only on an edge where `step` is 1, and then it loads `next_pc`. When `step` is 0 the PC keeps its value.
- R3: Class code 0 (sequential): `next_pc` is the PC plus `op_len` (1, 2 or 3), modulo 65536. This advanced value is called "adv" below.
- R4: Class code 1 (relative): when `take` is 1, `next_pc` is adv plus the signed 8-bit offset (−128..127), modulo 65536. The offset is `op_b3` when `op_len` is 3 and `op_b2` otherwise. When `take` is 0, `next_pc` is adv.
- R5: Class codes 2 (page jump) and 3 (page call): `next_pc` is {adv[15:11], op_b1[7:5], op_b2}. The target therefore stays in the 2 KB page of the advanced PC.
- R6: Class codes 4 (long jump) and 5 (long call): `next_pc` is {op_b2, op_b3}. `op_b2` is the high byte.
- R7: Class code 6 (computed jump): `next_pc` is the zero-extended accumulator plus `dptr`, modulo 65536.
- R8: Class code 7 (return): `next_pc` is {ret_hi, ret_lo}. `ret_hi` is the byte popped first.
- R9: For class codes 3 and 5, `push_req` equals `step`, `push_lo` is adv[7:0] (written to the stack first) and `push_hi` is adv[15:8]. For every other class, `push_req` is 0.
- R10: `tbl_addr` is the zero-extended accumulator plus adv when `tbl_pc` is 1, and plus `dptr` when `tbl_pc` is 0, modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step | input | 1 | Load the next PC on this edge |
| op_kind | input | 3 | Instruction class code (0..7) |
| op_len | input | 2 | Instruction length in bytes |
| op_b1 | input | 8 | First instruction byte (opcode) |
| op_b2 | input | 8 | Second instruction byte |
| op_b3 | input | 8 | Third instruction byte |
| take | input | 1 | Condition result for a relative branch |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| ret_hi | input | 8 | Byte popped first on a return |
| ret_lo | input | 8 | Byte popped second on a return |
| tbl_pc | input | 1 | Table base select: 1 = advanced PC, 0 = data pointer |
| pc | output | 16 | Current program counter |
| next_pc | output | 16 | Address of the next instruction |
| tbl_addr | output | 16 | Code address for a table lookup |
| push_req | output | 1 | Call return address is to be pushed |
| push_lo | output | 8 | Return address low byte, pushed first |
| push_hi | output | 8 | Return address high byte, pushed second |

## Verification
The bench walks the PC to the top of the address space and to a page edge. A design that skips the wrap would jump outside the 16-bit space. A design that takes the page bits from the unadvanced PC would land a jump placed at 0x07FE in the wrong 2 KB page. Backward displacements from near 0x0000 catch offsets that are zero-extended instead of sign-extended. Three-byte relative branches catch a displacement read from the wrong operand byte. A call at 0xFFFE must push 0x0000, and swapped push or pop byte order shows up as byte-reversed addresses. PC-based table reads catch a base taken before the PC advances.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 2;
  localparam int PAGE_W = 11;

  typedef enum logic [2:0] {
    K_SEQ   = 3'd0,
    K_REL   = 3'd1,
    K_PJMP  = 3'd2,
    K_PCALL = 3'd3,
    K_LJMP  = 3'd4,
    K_LCALL = 3'd5,
    K_JIDX  = 3'd6,
    K_RET   = 3'd7
  } pc_kind_e;

  function automatic logic [ADDR_W-1:0] f_advance(input logic [ADDR_W-1:0] cur,
                                                  input logic [LEN_W-1:0] len);
    return cur + {{(ADDR_W-LEN_W){1'b0}}, len};
  endfunction

  function automatic logic [ADDR_W-1:0] f_rel(input logic [ADDR_W-1:0] base,
                                              input logic [BYTE_W-1:0] off);
    return base + {{(ADDR_W-BYTE_W){off[BYTE_W-1]}}, off};
  endfunction

  function automatic logic [ADDR_W-1:0] f_page(input logic [ADDR_W-1:0] base,
                                               input logic [BYTE_W-1:0] opc,
                                               input logic [BYTE_W-1:0] lo);
    return {base[ADDR_W-1:PAGE_W], opc[BYTE_W-1 -: (PAGE_W-BYTE_W)], lo};
  endfunction

  function automatic logic [ADDR_W-1:0] f_index(input logic [BYTE_W-1:0] a,
                                                input logic [ADDR_W-1:0] base);
    return base + {{(ADDR_W-BYTE_W){1'b0}}, a};
  endfunction
endpackage

// File: rtl/pcb_advance.sv
`timescale 1ns/1ps
module pcb_advance
  import pcb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LEN_W
) (
  input  logic [AW-1:0] cur_pc,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] adv_pc
);
  always_comb adv_pc = f_advance(cur_pc, len);
endmodule

// File: rtl/pcb_target.sv
`timescale 1ns/1ps
module pcb_target
  import pcb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W,
  parameter int LW = LEN_W
) (
  input  logic [2:0]    kind,
  input  logic [LW-1:0] len,
  input  logic          take,
  input  logic [AW-1:0] adv_pc,
  input  logic [BW-1:0] b1,
  input  logic [BW-1:0] b2,
  input  logic [BW-1:0] b3,
  input  logic [BW-1:0] acc,
  input  logic [AW-1:0] dptr,
  input  logic [BW-1:0] ret_hi,
  input  logic [BW-1:0] ret_lo,
  output logic [AW-1:0] target,
  output logic          is_call
);
  localparam logic [LW-1:0] LEN_THREE = LW'(3);

  pc_kind_e      k;
  logic [BW-1:0] disp;

  always_comb begin
    k    = pc_kind_e'(kind);
    disp = (len == LEN_THREE) ? b3 : b2;
    unique case (k)
      K_SEQ:            target = adv_pc;
      K_REL:            target = take ? f_rel(adv_pc, disp) : adv_pc;
      K_PJMP, K_PCALL:  target = f_page(adv_pc, b1, b2);
      K_LJMP, K_LCALL:  target = {b2, b3};
      K_JIDX:           target = f_index(acc, dptr);
      K_RET:            target = {ret_hi, ret_lo};
      default:          target = adv_pc;
    endcase
    is_call = (k == K_PCALL) || (k == K_LCALL);
  end
endmodule

// File: rtl/pcb_table.sv
`timescale 1ns/1ps
module pcb_table
  import pcb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic [BW-1:0] acc,
  input  logic [AW-1:0] dptr,
  input  logic [AW-1:0] adv_pc,
  input  logic          use_pc,
  output logic [AW-1:0] addr
);
  always_comb addr = f_index(acc, use_pc ? adv_pc : dptr);
endmodule

// File: rtl/pc_branch_unit.sv
`timescale 1ns/1ps
module pc_branch_unit
  import pcb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [2:0]    op_kind,
  input  logic [LW-1:0] op_len,
  input  logic [BW-1:0] op_b1,
  input  logic [BW-1:0] op_b2,
  input  logic [BW-1:0] op_b3,
  input  logic          take,
  input  logic [BW-1:0] acc,
  input  logic [AW-1:0] dptr,
  input  logic [BW-1:0] ret_hi,
  input  logic [BW-1:0] ret_lo,
  input  logic          tbl_pc,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] tbl_addr,
  output logic          push_req,
  output logic [BW-1:0] push_lo,
  output logic [BW-1:0] push_hi
);
  localparam logic [AW-1:0] RESET_PC = '0;

  logic [AW-1:0] pc_q;
  logic [AW-1:0] adv_pc;
  logic          is_call;

  pcb_advance #(.AW(AW), .LW(LW)) i_adv (
    .cur_pc (pc_q),
    .len    (op_len),
    .adv_pc (adv_pc)
  );

  pcb_target #(.AW(AW), .BW(BW), .LW(LW)) i_tgt (
    .kind    (op_kind),
    .len     (op_len),
    .take    (take),
    .adv_pc  (adv_pc),
    .b1      (op_b1),
    .b2      (op_b2),
    .b3      (op_b3),
    .acc     (acc),
    .dptr    (dptr),
    .ret_hi  (ret_hi),
    .ret_lo  (ret_lo),
    .target  (next_pc),
    .is_call (is_call)
  );

  pcb_table #(.AW(AW), .BW(BW)) i_tbl (
    .acc    (acc),
    .dptr   (dptr),
    .adv_pc (adv_pc),
    .use_pc (tbl_pc),
    .addr   (tbl_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= RESET_PC;
    else if (step) pc_q <= next_pc;
  end

  always_comb begin
    pc       = pc_q;
    push_req = step & is_call;
    push_lo  = adv_pc[BW-1:0];
    push_hi  = adv_pc[AW-1:BW];
  end
endmodule

// File: rtl/pcb_checker.sv
`timescale 1ns/1ps
module pcb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic [2:0]  op_kind,
  input logic [1:0]  op_len,
  input logic [15:0] pc,
  input logic [15:0] next_pc,
  input logic [15:0] adv_pc,
  input logic        push_req,
  input logic [7:0]  push_lo,
  input logic [7:0]  push_hi
);
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> pc == 16'h0000);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc));

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> pc == $past(next_pc));

  a_r3_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == 3'd0) |-> next_pc == pc + {14'd0, op_len});

  a_r5_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == 3'd2 || op_kind == 3'd3) |-> next_pc[15:11] == adv_pc[15:11]);

  a_r9_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> {push_hi, push_lo} == pc + {14'd0, op_len});

  a_r9_push_only_call: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> (op_kind == 3'd3 || op_kind == 3'd5) && step);
endmodule

bind pc_branch_unit pcb_checker i_pcb_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step     (step),
  .op_kind  (op_kind),
  .op_len   (op_len),
  .pc       (pc),
  .next_pc  (next_pc),
  .adv_pc   (adv_pc),
  .push_req (push_req),
  .push_lo  (push_lo),
  .push_hi  (push_hi)
);

// File: tb/test_pc_branch_unit.sv
`timescale 1ns/1ps
module test_pc_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [2:0]  op_kind = '0;
  logic [1:0]  op_len = 2'd1;
  logic [7:0]  op_b1 = '0, op_b2 = '0, op_b3 = '0, acc = '0, ret_hi = '0, ret_lo = '0;
  logic        take = 1'b0, tbl_pc = 1'b0;
  logic [15:0] dptr = '0;
  logic [15:0] pc, next_pc, tbl_addr;
  logic        push_req;
  logic [7:0]  push_lo, push_hi;

  int n_run = 0, n_fail = 0;
  int model_pc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pc_branch_unit i_pc_branch_unit (
    .clk(clk), .rst_n(rst_n), .step(step), .op_kind(op_kind), .op_len(op_len),
    .op_b1(op_b1), .op_b2(op_b2), .op_b3(op_b3), .take(take), .acc(acc),
    .dptr(dptr), .ret_hi(ret_hi), .ret_lo(ret_lo), .tbl_pc(tbl_pc),
    .pc(pc), .next_pc(next_pc), .tbl_addr(tbl_addr), .push_req(push_req),
    .push_lo(push_lo), .push_hi(push_hi)
  );

  function automatic int wrap(input int v);
    return ((v % 65536) + 65536) % 65536;
  endfunction

  function automatic int exp_target(input int cur, input int k, input int len,
                                    input int b1, input int b2, input int b3,
                                    input bit tk, input int a, input int dp,
                                    input int rh, input int rl);
    int nxt, off, disp_byte;
    nxt = wrap(cur + len);
    case (k)
      1: begin
        disp_byte = (len == 3) ? b3 : b2;
        off = (disp_byte >= 128) ? disp_byte - 256 : disp_byte;
        return tk ? wrap(nxt + off) : nxt;
      end
      2, 3: return (nxt / 2048) * 2048 + (b1 / 32) * 256 + b2;
      4, 5: return b2 * 256 + b3;
      6:    return wrap(a + dp);
      7:    return rh * 256 + rl;
      default: return nxt;
    endcase
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4, 5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input int k, input int len, input int b1, input int b2,
                       input int b3, input bit tk, input int a, input int dp,
                       input int rh, input int rl, input bit tpc, input bit st);
    int exp_next, nxt, exp_tbl;
    bit callk;
    @(negedge clk);
    op_kind = 3'(k); op_len = 2'(len); op_b1 = 8'(b1); op_b2 = 8'(b2); op_b3 = 8'(b3);
    take = tk; acc = 8'(a); dptr = 16'(dp); ret_hi = 8'(rh); ret_lo = 8'(rl);
    tbl_pc = tpc; step = st;
    #1;
    nxt      = wrap(model_pc + len);
    exp_next = exp_target(model_pc, k, len, b1, b2, b3, tk, a, dp, rh, rl);
    exp_tbl  = wrap(a + (tpc ? nxt : dp));
    callk    = (k == 3) || (k == 5);
    check(tag_of(k), int'(next_pc), exp_next);
    check("R10", int'(tbl_addr), exp_tbl);
    check("R9 push_req", int'(push_req), int'(callk && st));
    if (callk) begin
      check("R9 push_lo", int'(push_lo), nxt % 256);
      check("R9 push_hi", int'(push_hi), nxt / 256);
    end
    @(negedge clk);
    if (st) model_pc = exp_next;
    check(st ? "R2 load" : "R2 hold", int'(pc), model_pc);
    step = 1'b0;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1", int'(pc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(pc), 0);

    // directed corner cases
    do_op(0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);            // R3 seq to 0003
    do_op(1, 2, 0, 8'h80, 0, 1, 0, 0, 0, 0, 0, 1);        // R4 backward wrap to FF85
    do_op(1, 3, 0, 8'h7F, 8'h05, 1, 0, 0, 0, 0, 0, 1);    // R4 offset from byte 3
    do_op(1, 2, 0, 8'h40, 0, 0, 0, 0, 0, 0, 0, 1);        // R4 not taken
    do_op(4, 3, 0, 8'h07, 8'hFE, 0, 0, 0, 0, 0, 1, 1);    // R6 to 07FE
    do_op(2, 2, 8'hE0, 8'h12, 0, 0, 0, 0, 0, 0, 0, 1);    // R5 page of 0800
    do_op(4, 3, 0, 8'hFF, 8'hFE, 0, 0, 0, 0, 0, 0, 1);    // R6 to FFFE
    do_op(3, 2, 8'h20, 8'h34, 0, 0, 0, 0, 0, 0, 0, 1);    // R9 call at FFFE pushes 0000
    do_op(5, 3, 0, 8'h12, 8'h34, 0, 8'hFF, 16'hFFF0, 0, 0, 1, 0); // R2 hold, R9 no push
    do_op(0, 1, 0, 0, 0, 0, 8'hF0, 0, 0, 0, 1, 1);        // R10 PC-based table
    do_op(6, 1, 0, 0, 0, 0, 8'h20, 16'hFFF0, 0, 0, 0, 1); // R7 wrap to 0010
    do_op(7, 1, 0, 0, 0, 0, 0, 0, 8'hAB, 8'hCD, 0, 1);    // R8 to ABCD
    do_op(5, 3, 0, 8'h04, 8'h3A, 0, 0, 0, 0, 0, 0, 1);    // R9 long call

    // constrained random
    for (int i = 0; i < 400; i++) begin
      int k, len;
      k = int'($urandom % 8);
      case (k)
        0: len = 1 + int'($urandom % 3);
        1: len = 2 + int'($urandom % 2);
        2, 3: len = 2;
        4, 5: len = 3;
        default: len = 1;
      endcase
      do_op(k, len, int'($urandom % 256), int'($urandom % 256), int'($urandom % 256),
            1'($urandom), int'($urandom % 256), int'($urandom % 65536),
            int'($urandom % 256), int'($urandom % 256), 1'($urandom),
            ($urandom % 8) != 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule